// File: doc/BRIEF.md
# Banked Shared Memory Crossbar with Per-Bank Round-Robin Arbitration

This block lets twenty bus masters share a local memory split into sixteen banks that can be used independently. Each master drives its own request port with a byte address, a write flag, a 64-bit write word and eight byte strobes. The address is decoded into a bank and a row on that master's own path. Every bank then runs its own round-robin arbiter over the masters aiming at it. Masters that target different banks are all served in the same cycle, and masters that collide on one bank take turns.

A single mode input picks the bank map at run time. In one mode consecutive words rotate across the banks. In the other, each bank owns one contiguous slice of the address space. A request is accepted in the cycle its grant is high. A master that is refused keeps its request steady until it is granted. A read returns its word on a per-master response port exactly one cycle after the grant.

Top module: `mbank_xbar`

## Requirements
- R1: After reset, with no requests, every grant and every response-valid output is low.
- R2: With `map_blocked` = 0 (interleaved map), byte address bits [6:3] select the bank and bits [12:7] select the row, so consecutive 8-byte words fall in consecutive banks.
- R3: With `map_blocked` = 1 (blocked map), byte address bits [12:9] select the bank and bits [8:3] select the row, so each bank holds one contiguous 512-byte region.
- R4: Each bank grants at most one master per cycle. Masters that request different banks in the same cycle are all granted in that cycle, and each master is granted by at most one bank.
- R5: Within a bank, the grant goes to the first requesting master found by searching upward from the bank's pointer, wrapping from master 19 to master 0. After a grant the pointer becomes the winner's index plus one, modulo 20. All pointers are 0 after reset. When all 20 masters contend for one bank, every one is served within 20 consecutive cycles.
- R6: The grant is combinational in the cycle of the request, and the request is taken on the clock edge that ends that cycle. A master that is not granted holds its request and address unchanged.
- R7: A granted read raises `rsp_valid` for that master only, exactly one cycle after the grant, with the addressed word on that master's `rsp_data` slice.
- R8: A granted write updates only the bytes whose strobe bit is set: strobe bit k controls data bits [8k+7:8k]. The other bytes of the word keep their old value.
- R9: A granted write produces no response: `rsp_valid` for that master stays low in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| map_blocked | input | 1 | 0 = interleaved bank map, 1 = blocked bank map |
| req_valid | input | 20 | Request valid, one bit per master |
| req_we | input | 20 | Write flag, one bit per master |
| req_addr | input | 260 | Byte address, 13 bits per master, master m at [13m+12:13m] |
| req_wdata | input | 1280 | Write word, 64 bits per master |
| req_be | input | 160 | Byte strobes, 8 bits per master |
| req_gnt | output | 20 | Grant, high in the cycle the request is accepted |
| rsp_valid | output | 20 | Read data valid, one cycle after a read grant |
| rsp_data | output | 1280 | Read word, 64 bits per master |

## Verification
The bench fills every word through the interleaved map and reads all of it back through the blocked map. A swapped or misplaced bank-select field therefore returns another bank's pattern. All twenty masters are piled onto a single bank under each map, and the grant vector is checked every cycle against an arithmetic pointer model. An arbiter that resets its pointer to zero, or that moves it to the winner instead of one past it, gives a wrong grant order or starves a high-numbered master. Sixteen masters aimed at distinct banks must all be granted together, and a write with a sparse strobe pattern must leave the unselected bytes untouched and produce no response.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic {
        MAP_INTERLEAVE = 1'b0,
        MAP_BLOCKED    = 1'b1
    } map_e;

endpackage

// File: rtl/mbx_decode.sv
module mbx_decode
    import mbx_pkg::*;
#(
    parameter int BB = 4,
    parameter int RB = 6,
    localparam int WA = BB + RB
) (
    input  logic [WA-1:0] word_addr,
    input  logic          blocked,
    output logic [BB-1:0] bank,
    output logic [RB-1:0] row
);

    map_e mode;

    always_comb begin
        mode = map_e'(blocked);
        if (mode == MAP_BLOCKED) begin
            bank = word_addr[WA-1:RB];
            row  = word_addr[RB-1:0];
        end else begin
            bank = word_addr[BB-1:0];
            row  = word_addr[WA-1:BB];
        end
    end

endmodule

// File: rtl/mbx_rr_arb.sv
module mbx_rr_arb #(
    parameter int N = 20,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  req,
    output logic [N-1:0]  gnt,
    output logic [IW-1:0] gnt_idx,
    output logic          gnt_any
);

    typedef struct packed {
        logic [IW-1:0] ptr;
    } arb_st_t;

    arb_st_t st_d, st_q;

    always_comb begin
        logic [IW:0] slot;
        st_d    = st_q;
        gnt     = '0;
        gnt_idx = '0;
        gnt_any = 1'b0;
        for (int i = 0; i < N; i++) begin
            slot = {1'b0, st_q.ptr} + (IW+1)'(i);
            if (slot >= (IW+1)'(N)) begin
                slot = slot - (IW+1)'(N);
            end
            if (!gnt_any && req[slot[IW-1:0]]) begin
                gnt_any = 1'b1;
                gnt_idx = slot[IW-1:0];
            end
        end
        if (gnt_any) begin
            gnt[gnt_idx] = 1'b1;
            st_d.ptr = (gnt_idx == IW'(N-1)) ? '0 : gnt_idx + IW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    AST_GNT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt)); // R4

    for (genvar g = 0; g < N; g++) begin : g_wait
        logic [IW:0] wait_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                wait_q <= '0;
            end else if (req[g] && !gnt[g]) begin
                wait_q <= wait_q + (IW+1)'(1);
            end else begin
                wait_q <= '0;
            end
        end
        AST_NO_STARVE: assert property (@(posedge clk) disable iff (!rst_n)
            wait_q < (IW+1)'(N)); // R5
    end

endmodule

// File: rtl/mbx_bank.sv
module mbx_bank
    import mbx_pkg::*;
#(
    parameter int WB = 8,
    parameter int RB = 6,
    localparam int DW = WB * BYTE_W,
    localparam int DEPTH = 1 << RB
) (
    input  logic          clk,
    input  logic          en,
    input  logic          we,
    input  logic [RB-1:0] row,
    input  logic [DW-1:0] wdata,
    input  logic [WB-1:0] be,
    output logic [DW-1:0] rdata
);

    logic [DW-1:0] mem [DEPTH];
    logic [DW-1:0] rdata_q;

    always_ff @(posedge clk) begin
        if (en && we) begin
            for (int k = 0; k < WB; k++) begin
                if (be[k]) begin
                    mem[row][k*BYTE_W +: BYTE_W] <= wdata[k*BYTE_W +: BYTE_W];
                end
            end
        end
        if (en && !we) begin
            rdata_q <= mem[row];
        end
    end

    assign rdata = rdata_q;

endmodule

// File: rtl/mbank_xbar.sv
module mbank_xbar
    import mbx_pkg::*;
#(
    parameter int N_MASTERS  = 20,
    parameter int N_BANKS    = 16,
    parameter int WORD_BYTES = 8,
    parameter int BANK_WORDS = 64,
    localparam int NM  = N_MASTERS,
    localparam int NB  = N_BANKS,
    localparam int WB  = WORD_BYTES,
    localparam int DW  = WB * BYTE_W,
    localparam int OFF = $clog2(WB),
    localparam int BB  = $clog2(NB),
    localparam int RB  = $clog2(BANK_WORDS),
    localparam int AW  = OFF + BB + RB,
    localparam int MW  = (NM > 1) ? $clog2(NM) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             map_blocked,
    input  logic [NM-1:0]    req_valid,
    input  logic [NM-1:0]    req_we,
    input  logic [NM*AW-1:0] req_addr,
    input  logic [NM*DW-1:0] req_wdata,
    input  logic [NM*WB-1:0] req_be,
    output logic [NM-1:0]    req_gnt,
    output logic [NM-1:0]    rsp_valid,
    output logic [NM*DW-1:0] rsp_data
);

    typedef struct packed {
        logic [NM-1:0]         rvalid;
        logic [NM-1:0][BB-1:0] rbank;
    } rsp_st_t;

    logic [BB-1:0] dec_bank [NM];
    logic [RB-1:0] dec_row  [NM];

    logic [NM-1:0] bank_req  [NB];
    logic [NM-1:0] bank_gnt  [NB];
    logic [MW-1:0] bank_sel  [NB];
    logic          bank_act  [NB];
    logic [DW-1:0] bank_rdata[NB];
    logic [NB-1:0] m_hits    [NM];

    rsp_st_t rsp_d, rsp_q;

    // address decode on each master's private path
    for (genvar m = 0; m < NM; m++) begin : g_dec
        mbx_decode #(
            .BB (BB),
            .RB (RB)
        ) u_dec (
            .word_addr (req_addr[m*AW+OFF +: BB+RB]),
            .blocked   (map_blocked),
            .bank      (dec_bank[m]),
            .row       (dec_row[m])
        );
    end

    // request matrix: bank b sees master m when m targets b
    always_comb begin
        for (int b = 0; b < NB; b++) begin
            for (int m = 0; m < NM; m++) begin
                bank_req[b][m] = req_valid[m] && (dec_bank[m] == BB'(b));
            end
        end
    end

    // one arbiter and one array per bank
    for (genvar b = 0; b < NB; b++) begin : g_bank
        mbx_rr_arb #(
            .N (NM)
        ) u_arb (
            .clk     (clk),
            .rst_n   (rst_n),
            .req     (bank_req[b]),
            .gnt     (bank_gnt[b]),
            .gnt_idx (bank_sel[b]),
            .gnt_any (bank_act[b])
        );

        mbx_bank #(
            .WB (WB),
            .RB (RB)
        ) u_mem (
            .clk   (clk),
            .en    (bank_act[b]),
            .we    (req_we[bank_sel[b]]),
            .row   (dec_row[bank_sel[b]]),
            .wdata (req_wdata[bank_sel[b]*DW +: DW]),
            .be    (req_be[bank_sel[b]*WB +: WB]),
            .rdata (bank_rdata[b])
        );
    end

    // grant return and response tracking
    always_comb begin
        rsp_d = rsp_q;
        for (int m = 0; m < NM; m++) begin
            for (int b = 0; b < NB; b++) begin
                m_hits[m][b] = bank_gnt[b][m];
            end
            req_gnt[m] = |m_hits[m];
            rsp_d.rvalid[m] = req_gnt[m] && !req_we[m];
            if (req_gnt[m]) begin
                rsp_d.rbank[m] = dec_bank[m];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_q <= '0;
        end else begin
            rsp_q <= rsp_d;
        end
    end

    always_comb begin
        for (int m = 0; m < NM; m++) begin
            rsp_data[m*DW +: DW] = bank_rdata[rsp_q.rbank[m]];
        end
    end

    assign rsp_valid = rsp_q.rvalid;

    for (genvar m = 0; m < NM; m++) begin : g_chk
        AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            req_valid[m] && !req_gnt[m] |=> req_valid[m] && $stable(req_addr[m*AW +: AW])); // R6
        AST_GNT_HAS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
            req_gnt[m] |-> req_valid[m]); // R4
        AST_ONE_BANK_PER_MASTER: assert property (@(posedge clk) disable iff (!rst_n)
            $countones(m_hits[m]) <= 1); // R4
        AST_RSP_AFTER_GNT: assert property (@(posedge clk) disable iff (!rst_n)
            rsp_valid[m] |-> $past(req_gnt[m])); // R7
        AST_WRITE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
            req_gnt[m] && req_we[m] |=> !rsp_valid[m]); // R9
    end

endmodule

// File: tb/mbank_xbar_bench.sv
module mbank_xbar_bench;

    localparam int NM = 20;
    localparam int NB = 16;
    localparam int AW = 13;
    localparam int DW = 64;
    localparam int WB = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mode = 1'b0;

    logic [NM-1:0]    req_valid, req_we, req_gnt, rsp_valid;
    logic [NM*AW-1:0] req_addr;
    logic [NM*DW-1:0] req_wdata, rsp_data;
    logic [NM*WB-1:0] req_be;

    always #4 clk = ~clk;

    mbank_xbar u_mbank_xbar (
        .clk         (clk),
        .rst_n       (rst_n),
        .map_blocked (mode),
        .req_valid   (req_valid),
        .req_we      (req_we),
        .req_addr    (req_addr),
        .req_wdata   (req_wdata),
        .req_be      (req_be),
        .req_gnt     (req_gnt),
        .rsp_valid   (rsp_valid),
        .rsp_data    (rsp_data)
    );

    // pending requests (driven), staged requests, clears
    logic          pv [NM], pwe [NM], sv [NM], swe [NM], clr [NM];
    logic [AW-1:0] pa [NM], sa [NM];
    logic [DW-1:0] pd [NM], sd [NM];
    logic [WB-1:0] pbe [NM], sbe [NM];

    logic [DW-1:0] shadow [NB][64];
    int            ptr [NB];
    logic [NM-1:0] exp_rv;
    logic [DW-1:0] exp_rd [NM];
    bit            have_exp = 0;
    string         cur_tag = "R2";

    int n_chk = 0;
    int n_fail = 0;
    int cycles = 0;

    always_comb begin
        for (int m = 0; m < NM; m++) begin
            req_valid[m]          = pv[m];
            req_we[m]             = pwe[m];
            req_addr[m*AW +: AW]  = pa[m];
            req_wdata[m*DW +: DW] = pd[m];
            req_be[m*WB +: WB]    = pbe[m];
        end
    end

    function automatic int bank_of(logic [AW-1:0] a, logic blk);
        return blk ? int'(a[12:9]) : int'(a[6:3]);
    endfunction

    function automatic int row_of(logic [AW-1:0] a, logic blk);
        return blk ? int'(a[8:3]) : int'(a[12:7]);
    endfunction

    function automatic logic [AW-1:0] addr_il(int b, int r);
        return AW'(r * 128 + b * 8);
    endfunction

    function automatic logic [AW-1:0] addr_bl(int b, int r);
        return AW'(b * 512 + r * 8);
    endfunction

    function automatic logic [DW-1:0] pat(int b, int r);
        return {8'(b), 8'(r), 16'hBEEF, 8'(r) ^ 8'h5A, 8'(b) ^ 8'hC3, 16'h1234};
    endfunction

    task automatic chk(bit ok, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", what, act, exp);
        end
    endtask

    task automatic post(int m, logic we, logic [AW-1:0] a, logic [DW-1:0] d, logic [WB-1:0] be);
        sv[m] = 1'b1; swe[m] = we; sa[m] = a; sd[m] = d; sbe[m] = be;
    endtask

    function automatic bit busy();
        for (int m = 0; m < NM; m++) begin
            if (pv[m] || sv[m] || clr[m]) return 1'b1;
        end
        return 1'b0;
    endfunction

    task automatic step();
        logic [NM-1:0] eg;
        @(negedge clk);
        cycles++;
        if (have_exp) begin
            chk(rsp_valid === exp_rv, "R7 R9 rsp_valid vector", DW'(rsp_valid), DW'(exp_rv));
            for (int m = 0; m < NM; m++) begin
                if (exp_rv[m]) begin
                    chk(rsp_data[m*DW +: DW] === exp_rd[m], {cur_tag, " R7 read data"},
                        rsp_data[m*DW +: DW], exp_rd[m]);
                end
            end
        end
        for (int m = 0; m < NM; m++) begin
            if (clr[m]) pv[m] = 1'b0;
            if (sv[m]) begin
                pv[m] = 1'b1; pwe[m] = swe[m]; pa[m] = sa[m]; pd[m] = sd[m]; pbe[m] = sbe[m];
            end
            sv[m] = 1'b0;
            clr[m] = 1'b0;
        end
        #1;
        eg = '0;
        for (int b = 0; b < NB; b++) begin
            bit found = 0;
            for (int i = 0; i < NM; i++) begin
                int idx = (ptr[b] + i) % NM;
                if (!found && pv[idx] && bank_of(pa[idx], mode) == b) begin
                    found = 1;
                    eg[idx] = 1'b1;
                    ptr[b] = (idx + 1) % NM;
                end
            end
        end
        chk(req_gnt === eg, {cur_tag, " R4 R5 R6 grant vector"}, DW'(req_gnt), DW'(eg));
        exp_rv = '0;
        for (int m = 0; m < NM; m++) begin
            if (eg[m]) begin
                int b = bank_of(pa[m], mode);
                int r = row_of(pa[m], mode);
                if (pwe[m]) begin
                    for (int k = 0; k < WB; k++) begin
                        if (pbe[m][k]) shadow[b][r][k*8 +: 8] = pd[m][k*8 +: 8];
                    end
                end else begin
                    exp_rv[m] = 1'b1;
                    exp_rd[m] = shadow[b][r];
                end
                clr[m] = 1'b1;
            end
        end
        have_exp = 1;
    endtask

    task automatic drain();
        while (busy()) step();
        step();
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired (all requirements) actual=hung expected=done");
        finish_run();
    end

    initial begin
        int c0;
        logic [DW-1:0] nw;
        for (int m = 0; m < NM; m++) begin
            pv[m] = 0; pwe[m] = 0; pa[m] = '0; pd[m] = '0; pbe[m] = '0;
            sv[m] = 0; swe[m] = 0; sa[m] = '0; sd[m] = '0; sbe[m] = '0; clr[m] = 0;
            exp_rd[m] = '0;
        end
        for (int b = 0; b < NB; b++) ptr[b] = 0;
        exp_rv = '0;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        // R1: quiet after reset
        chk(req_gnt === '0, "R1 grant after reset", DW'(req_gnt), '0);
        chk(rsp_valid === '0, "R1 rsp_valid after reset", DW'(rsp_valid), '0);

        // R2 fill: 16 masters write distinct banks together each cycle
        cur_tag = "R2 R4";
        mode = 1'b0;
        for (int r = 0; r < 64; r++) begin
            for (int b = 0; b < NB; b++) post(b, 1'b1, addr_il(b, r), pat(b, r), 8'hFF);
            drain();
        end

        // R3 readback through the blocked map
        cur_tag = "R3 R4";
        mode = 1'b1;
        for (int r = 0; r < 64; r++) begin
            for (int b = 0; b < NB; b++) post((b + r) % NM, 1'b0, addr_bl(b, r), '0, '0);
            drain();
        end

        // direct R3 check of one cross-mapped word
        cur_tag = "R3";
        post(17, 1'b0, addr_bl(5, 1), '0, '0);
        step();
        step();
        chk(rsp_valid[17] && rsp_data[17*DW +: DW] === pat(5, 1),
            "R3 blocked read of word written at interleaved 0x0A8",
            rsp_data[17*DW +: DW], pat(5, 1));
        drain();

        // R5: all masters contend for one bank, interleaved map
        cur_tag = "R5 R6";
        mode = 1'b0;
        c0 = cycles;
        for (int m = 0; m < NM; m++) post(m, 1'b0, addr_il(5, m), '0, '0);
        drain();
        chk((cycles - c0) == 22, "R5 all 20 served in 20 grant cycles (interleaved)",
            DW'(cycles - c0), DW'(22));

        // R5: same under the blocked map, another bank
        mode = 1'b1;
        c0 = cycles;
        for (int m = 0; m < NM; m++) post(m, 1'b0, addr_bl(9, 63 - m), '0, '0);
        drain();
        chk((cycles - c0) == 22, "R5 all 20 served in 20 grant cycles (blocked)",
            DW'(cycles - c0), DW'(22));

        // R4 R5: sparse contention with a mixed write
        cur_tag = "R4 R5";
        mode = 1'b0;
        post(2, 1'b0, addr_il(3, 4), '0, '0);
        post(7, 1'b0, addr_il(3, 9), '0, '0);
        post(13, 1'b0, addr_il(3, 10), '0, '0);
        post(19, 1'b0, addr_il(3, 11), '0, '0);
        post(0, 1'b1, addr_il(3, 10), 64'hDEAD_0000_BEEF_0000, 8'hFF);
        post(1, 1'b0, addr_il(4, 2), '0, '0);
        drain();

        // R8 R9: sparse strobes, then read back
        cur_tag = "R8";
        nw = 64'h1122_3344_5566_7788;
        post(4, 1'b1, addr_il(7, 2), nw, 8'hA5);
        step();
        step();
        chk(rsp_valid[4] === 1'b0, "R9 no response after write", DW'(rsp_valid[4]), '0);
        drain();
        post(4, 1'b0, addr_il(7, 2), '0, '0);
        step();
        step();
        chk(rsp_data[4*DW +: DW] === ((pat(7, 2) & 64'h00FF_00FF_FF00_FF00) |
                                      (nw & 64'hFF00_FF00_00FF_00FF)),
            "R8 byte merge with strobes 0xA5", rsp_data[4*DW +: DW],
            (pat(7, 2) & 64'h00FF_00FF_FF00_FF00) | (nw & 64'hFF00_FF00_00FF_00FF));
        drain();

        finish_run();
    end

endmodule